// File: doc/BRIEF.md
# Injection Rounding Back End for a Dual-Precision Significand Multiplier

This block finishes a floating-point significand multiply. Before the product is formed, a small constant chosen only by the rounding mode and the product sign is added into the multiplier's addition tree. Once that constant is in, every rounding mode reduces to plain truncation for products below 2. The block supplies that constant on a separate issue-side port, `inj_o`. On the rounding side it takes the 54 upper carry-save digits of the product, which already include the constant. It also takes three bits resolved by the carry/sticky stage: the carry into the lowest kept position, the round bit and the sticky bit. From these it returns a rounded, normalized 53-bit significand one clock later.

The same datapath serves both precisions. A single-precision product arrives shifted 29 places right, so its last kept bit sits where the double-precision one does and the rounding positions coincide. A compound adder forms sum, sum+1 and sum+2 in units of the last place. The carry-in picks a pair (x, x+1) from those three. A single increment select then adds the correction the constant needs when the product lies in [2,4), and the result is shifted right one place in that case. Two fixes follow. On a round-to-nearest tie the last bit is pulled low. The two bits left of the binary point are ORed, so that a carry out of the top bit still yields a normalized significand. Exponent adjustment and exception flags are handled elsewhere.

Top module: `rb_round_backend`

## Requirements
- R1: `inj_o` bit k has weight 2^-(105-k). Mode codes are 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. The injection is 0 when the mode truncates the magnitude. It is bit 52 alone (2^-53) for nearest-even. It is bits 52..0 all set (2^-52 - 2^-105) when the mode rounds the magnitude up.
- R2: Toward +infinity rounds the magnitude up for a positive sign (`rnd_sign_i`=0) and truncates it for a negative sign. Toward -infinity does the opposite. The result is the correctly rounded significand of the exact product.
- R3: Nearest-even returns the correctly rounded significand for products in [1,2) and in [2,4). This includes exact ties, which go to the even neighbour.
- R4: Toward zero returns the exact significand truncated to 53 bits (24 bits in single precision).
- R5: When rounding carries past the largest significand, the result is 1.0: only `res_sig_o[52]` set (only bit 52 of the single field in single precision).
- R6: With `rnd_dbl_i`=0, the 24-bit single-precision result is in `res_sig_o[52:29]` and `res_sig_o[28:0]` is zero. Its input product is the double-aligned product times 2^-29.
- R7: Every valid result has `res_sig_o[52]`=1.
- R8: `res_vld_o` equals `rnd_vld_i` of the previous cycle. `res_sig_o` carries the result for the inputs presented in that cycle. Both outputs are 0 while `rst_n` is low.
- R9: The result depends only on the value that the carry-save digits, carry-in, round bit and sticky bit represent, not on how that value is split between `sum_hi_i` and `cry_hi_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_sign_i | input | 1 | Product sign at issue |
| iss_mode_i | input | 2 | Rounding mode at issue (R1 codes) |
| inj_o | output | 105 | Injection constant for the addition tree; bit k weighs 2^-(105-k) |
| rnd_vld_i | input | 1 | Rounding inputs valid this cycle |
| rnd_dbl_i | input | 1 | 1 double precision, 0 single precision |
| rnd_sign_i | input | 1 | Product sign at the rounding stage |
| rnd_mode_i | input | 2 | Rounding mode at the rounding stage (R1 codes) |
| sum_hi_i | input | 54 | Sum digits, bit k weighs 2^(k-52) |
| cry_hi_i | input | 54 | Carry digits, same weights as `sum_hi_i` |
| cin_i | input | 1 | Carry from the lower digits into weight 2^-52 |
| rbit_i | input | 1 | Resolved bit of weight 2^-53 (injection included) |
| sbit_i | input | 1 | OR of all resolved bits below 2^-53 |
| res_vld_o | output | 1 | Result valid |
| res_sig_o | output | 53 | Rounded significand, bit 52 weighs 2^0 |

## Verification
Most internal faults here show up as a result one unit in the last place off. Examples are a wrong pair select from the carry-in, a wrong top-bit choice, or a misapplied injection correction. Each such error appears in the very next cycle, but only for the product ranges and modes that use the faulty path. The reference model therefore rounds the exact product itself, and stimulus is spread across [1,2) and [2,4), both signs and both precisions. The tie fix and the overflow OR are visible only on midpoint products and near-2 products. Those are driven directly, each with two different carry-save splits, so that a split-dependent fault changes the output.

// File: rtl/rb_pkg.sv
package rb_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_TO_POS    = 2'b10,
      RM_TO_NEG    = 2'b11
   } ieee_rm_e;

   typedef enum logic [1:0] {
      RR_TRUNC   = 2'b00,
      RR_HALF_UP = 2'b01,
      RR_AWAY    = 2'b10
   } red_rm_e;

   // Fold the sign into the mode so only magnitude rounding remains.
   function automatic red_rm_e reduce_rm(input ieee_rm_e rm, input logic neg);
      red_rm_e r;
      case (rm)
         RM_NEAR_EVEN: r = RR_HALF_UP;
         RM_TO_ZERO:   r = RR_TRUNC;
         RM_TO_POS:    r = neg ? RR_TRUNC : RR_AWAY;
         default:      r = neg ? RR_AWAY : RR_TRUNC;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rb_inject_gen.sv
module rb_inject_gen
   import rb_pkg::*;
#(
   parameter int FRAC_W = 52
) (
   input  logic              neg_i,
   input  logic [1:0]        rm_i,
   output logic [2*FRAC_W:0] inj_o
);

   localparam int INJ_W = 2*FRAC_W + 1;

   red_rm_e red;
   assign red = reduce_rm(ieee_rm_e'(rm_i), neg_i);

   // Bit FRAC_W is half a unit in the last place; everything below it
   // fills out "one unit minus the smallest product weight".
   for (genvar k = 0; k < INJ_W; k++) begin : g_bit
      if (k > FRAC_W) begin : g_zero
         assign inj_o[k] = 1'b0;
      end else if (k == FRAC_W) begin : g_half
         assign inj_o[k] = (red != RR_TRUNC);
      end else begin : g_tail
         assign inj_o[k] = (red == RR_AWAY);
      end
   end

endmodule

// File: rtl/rb_compound_add.sv
module rb_compound_add #(
   parameter int W          = 54,
   parameter bit SHARED_INC = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] s0_o,
   output logic [W-1:0] s1_o,
   output logic [W-1:0] s2_o
);

   if (W < 4) begin : g_bad_w
      $error("rb_compound_add: W too small");
   end

   if (SHARED_INC) begin : g_shared
      // One carry-propagate adder followed by two short increments.
      assign s0_o = a_i + b_i;
      assign s1_o = s0_o + W'(1);
      assign s2_o = s0_o + W'(2);
   end else begin : g_parallel
      // Three independent adders: less depth, more area.
      assign s0_o = a_i + b_i;
      assign s1_o = a_i + b_i + W'(1);
      assign s2_o = a_i + b_i + W'(2);
   end

endmodule

// File: rtl/rb_incr_select.sv
module rb_incr_select
   import rb_pkg::*;
#(
   parameter int W      = 54,
   parameter int SP_MSB = 24,
   parameter bit SGL_EN = 1'b1
) (
   input  logic [W-1:0] s0_i,
   input  logic [W-1:0] s1_i,
   input  logic [W-1:0] s2_i,
   input  logic         cin_i,
   input  logic         rbit_i,
   input  logic         dbl_i,
   input  red_rm_e      red_i,
   output logic [W-1:0] y_o,
   output logic         msb_o,
   output logic         xlsb_o
);

   logic [W-1:0] x_lo;
   logic [W-1:0] x_hi;
   logic         inc;

   // Carry from the lower digits chooses the pair (x, x+1).
   assign x_lo = cin_i ? s1_i : s0_i;
   assign x_hi = cin_i ? s2_i : s1_i;

   if (SGL_EN) begin : g_dual_msb
      assign msb_o = dbl_i ? s0_i[W-1] : s0_i[SP_MSB];
   end else begin : g_dbl_msb
      assign msb_o = s0_i[W-1];
   end

   // Correction of the early constant for products in [2,4).
   assign inc    = msb_o & ((red_i == RR_AWAY) | ((red_i == RR_HALF_UP) & rbit_i));
   assign y_o    = inc ? x_hi : x_lo;
   assign xlsb_o = x_lo[0];

endmodule

// File: rtl/rb_lsb_msb_fix.sv
module rb_lsb_msb_fix #(
   parameter int W      = 54,
   parameter int SP_SH  = 29,
   parameter bit SGL_EN = 1'b1
) (
   input  logic [W-1:0] y_i,
   input  logic         msb_i,
   input  logic         xlsb_i,
   input  logic         rbit_i,
   input  logic         sbit_i,
   input  logic         rne_i,
   input  logic         dbl_i,
   output logic [W-2:0] sig_o
);

   localparam int SP_MSB = W - 1 - SP_SH;

   if (SP_SH < 1 || SP_MSB < 3) begin : g_bad_cfg
      $error("rb_lsb_msb_fix: shift leaves no single-precision field");
   end

   logic [W-1:0] z;
   logic         tie;
   logic         lsb;
   logic [W-2:0] dsig;

   assign z = msb_i ? {1'b0, y_i[W-1:1]} : y_i;

   // Midpoint detect on the value that already carries the injection.
   assign tie = rne_i & ~sbit_i & (msb_i ? (rbit_i & xlsb_i) : ~rbit_i);
   assign lsb = z[0] & ~tie;

   assign dsig = {z[W-1] | z[W-2], z[W-3:1], lsb};

   if (SGL_EN) begin : g_dual_out
      logic [W-2:0] ssig;
      assign ssig  = {z[SP_MSB] | z[SP_MSB-1], z[SP_MSB-2:1], lsb, {SP_SH{1'b0}}};
      assign sig_o = dbl_i ? dsig : ssig;
   end else begin : g_dbl_out
      assign sig_o = dsig;
   end

endmodule

// File: rtl/rb_round_backend.sv
module rb_round_backend
   import rb_pkg::*;
#(
   parameter int FRAC_W     = 52,
   parameter int SP_FRAC_W  = 23,
   parameter bit SGL_EN     = 1'b1,
   parameter bit SHARED_INC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_sign_i,
   input  logic [1:0]        iss_mode_i,
   output logic [2*FRAC_W:0] inj_o,
   input  logic              rnd_vld_i,
   input  logic              rnd_dbl_i,
   input  logic              rnd_sign_i,
   input  logic [1:0]        rnd_mode_i,
   input  logic [FRAC_W+1:0] sum_hi_i,
   input  logic [FRAC_W+1:0] cry_hi_i,
   input  logic              cin_i,
   input  logic              rbit_i,
   input  logic              sbit_i,
   output logic              res_vld_o,
   output logic [FRAC_W:0]   res_sig_o
);

   localparam int HI_W   = FRAC_W + 2;
   localparam int SIG_W  = FRAC_W + 1;
   localparam int SP_SH  = FRAC_W - SP_FRAC_W;
   localparam int SP_MSB = HI_W - 1 - SP_SH;

   if (SP_FRAC_W < 2 || SP_FRAC_W + 2 > FRAC_W) begin : g_bad_prec
      $error("rb_round_backend: SP_FRAC_W must be at least 2 and well below FRAC_W");
   end

   rb_inject_gen #(.FRAC_W(FRAC_W)) u_inj (
      .neg_i (iss_sign_i),
      .rm_i  (iss_mode_i),
      .inj_o (inj_o)
   );

   red_rm_e rnd_red;
   assign rnd_red = reduce_rm(ieee_rm_e'(rnd_mode_i), rnd_sign_i);

   logic [HI_W-1:0] s0, s1, s2;

   rb_compound_add #(.W(HI_W), .SHARED_INC(SHARED_INC)) u_add (
      .a_i  (sum_hi_i),
      .b_i  (cry_hi_i),
      .s0_o (s0),
      .s1_o (s1),
      .s2_o (s2)
   );

   logic [HI_W-1:0] y;
   logic            msb;
   logic            xlsb;

   rb_incr_select #(.W(HI_W), .SP_MSB(SP_MSB), .SGL_EN(SGL_EN)) u_sel (
      .s0_i   (s0),
      .s1_i   (s1),
      .s2_i   (s2),
      .cin_i  (cin_i),
      .rbit_i (rbit_i),
      .dbl_i  (rnd_dbl_i),
      .red_i  (rnd_red),
      .y_o    (y),
      .msb_o  (msb),
      .xlsb_o (xlsb)
   );

   logic [SIG_W-1:0] sig_d;

   rb_lsb_msb_fix #(.W(HI_W), .SP_SH(SP_SH), .SGL_EN(SGL_EN)) u_fix (
      .y_i    (y),
      .msb_i  (msb),
      .xlsb_i (xlsb),
      .rbit_i (rbit_i),
      .sbit_i (sbit_i),
      .rne_i  (rnd_red == RR_HALF_UP),
      .dbl_i  (rnd_dbl_i),
      .sig_o  (sig_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld_o <= 1'b0;
         res_sig_o <= '0;
      end else begin
         res_vld_o <= rnd_vld_i;
         if (rnd_vld_i) begin
            res_sig_o <= sig_d;
         end
      end
   end

endmodule

// File: rtl/rb_round_backend_chk.sv
module rb_round_backend_chk #(
   parameter int FRAC_W    = 52,
   parameter int SP_FRAC_W = 23
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        iss_mode_i,
   input logic [2*FRAC_W:0] inj_o,
   input logic              rnd_vld_i,
   input logic              rnd_dbl_i,
   input logic              res_vld_o,
   input logic [FRAC_W:0]   res_sig_o
);

   localparam int SP_SH = FRAC_W - SP_FRAC_W;

   // R1: nearest-even injects exactly the half-unit weight
   assert_inj_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_mode_i == 2'b00) |-> (($countones(inj_o) == 1) && inj_o[FRAC_W]));

   // R1: toward zero injects nothing
   assert_inj_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_mode_i == 2'b01) |-> (inj_o == '0));

   // R8: a valid input yields a valid result one cycle later
   assert_vld_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_vld_i |=> res_vld_o);

   // R8: no result without an input
   assert_vld_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rnd_vld_i |=> !res_vld_o);

   // R7: results are normalized
   assert_norm_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_o |-> res_sig_o[FRAC_W]);

   // R6: single-precision results are left-justified with a zero tail
   assert_sgl_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rnd_vld_i && !rnd_dbl_i) |=> (res_sig_o[SP_SH-1:0] == '0));

endmodule

bind rb_round_backend rb_round_backend_chk #(
   .FRAC_W    (FRAC_W),
   .SP_FRAC_W (SP_FRAC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .iss_mode_i (iss_mode_i),
   .inj_o      (inj_o),
   .rnd_vld_i  (rnd_vld_i),
   .rnd_dbl_i  (rnd_dbl_i),
   .res_vld_o  (res_vld_o),
   .res_sig_o  (res_sig_o)
);

// File: tb/rb_round_backend_bench.sv
module rb_round_backend_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         iss_sign = 1'b0;
   logic [1:0]   iss_mode = 2'b00;
   logic [104:0] inj;
   logic         rnd_vld = 1'b0;
   logic         rnd_dbl = 1'b1;
   logic         rnd_sign = 1'b0;
   logic [1:0]   rnd_mode = 2'b00;
   logic [53:0]  sum_hi = '0;
   logic [53:0]  cry_hi = '0;
   logic         cin = 1'b0;
   logic         rbit = 1'b0;
   logic         sbit = 1'b0;
   logic         res_vld;
   logic [52:0]  res_sig;

   int          checks = 0;
   int          fails = 0;
   bit          pend_vld = 1'b0;
   logic [52:0] pend_exp = '0;
   string       pend_tag = "";

   always #10 clk = ~clk;

   rb_round_backend u_rb_round_backend (
      .clk        (clk),
      .rst_n      (rst_n),
      .iss_sign_i (iss_sign),
      .iss_mode_i (iss_mode),
      .inj_o      (inj),
      .rnd_vld_i  (rnd_vld),
      .rnd_dbl_i  (rnd_dbl),
      .rnd_sign_i (rnd_sign),
      .rnd_mode_i (rnd_mode),
      .sum_hi_i   (sum_hi),
      .cry_hi_i   (cry_hi),
      .cin_i      (cin),
      .rbit_i     (rbit),
      .sbit_i     (sbit),
      .res_vld_o  (res_vld),
      .res_sig_o  (res_sig)
   );

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit rounds_away(input logic [1:0] mode, input bit sign);
      return (mode == 2'b10 && !sign) || (mode == 2'b11 && sign);
   endfunction

   // Injection in units of 2^-105 (R1)
   function automatic logic [127:0] inj_val(input logic [1:0] mode, input bit sign);
      if (mode == 2'b00) return 128'(1) << 52;
      if (rounds_away(mode, sign)) return (128'(1) << 53) - 128'(1);
      return 128'(0);
   endfunction

   // Exact product in units of 2^-105
   function automatic logic [127:0] exact(input bit dbl, input logic [52:0] a, input logic [52:0] b);
      logic [127:0] p;
      p = 128'(a) * 128'(b);
      return dbl ? (p << 1) : (p << 30);
   endfunction

   // IEEE reference rounding of the exact product
   function automatic logic [52:0] ref_round(input bit dbl, input bit sign, input logic [1:0] mode,
                                             input logic [52:0] a, input logic [52:0] b);
      logic [127:0] ev, q, rem, half, lim;
      int sh;
      bit ovf, up;
      ev   = exact(dbl, a, b);
      ovf  = dbl ? ev[106] : ev[77];
      sh   = ovf ? 54 : 53;
      q    = ev >> sh;
      rem  = ev & ((128'(1) << sh) - 128'(1));
      half = 128'(1) << (sh - 1);
      case (mode)
         2'b00:   up = (rem > half) || (rem == half && q[0]);
         2'b01:   up = 1'b0;
         default: up = rounds_away(mode, sign) && (rem != 0);
      endcase
      q   = q + 128'(up);
      lim = dbl ? (128'(1) << 53) : (128'(1) << 24);
      if (q == lim) q = lim >> 1;
      if (!dbl) q = q << 29;
      return q[52:0];
   endfunction

   task automatic settle();
      chk("R8", "valid", 128'(res_vld), 128'(pend_vld));
      if (pend_vld) chk(pend_tag, "significand", 128'(res_sig), 128'(pend_exp));
   endtask

   task automatic run_op(input bit dbl, input bit sign, input logic [1:0] mode,
                         input logic [52:0] a, input logic [52:0] b,
                         input bit split, input string tag);
      logic [127:0] t, iv;
      logic [52:0]  slo, clo;
      logic [53:0]  lsum, thi, shi, chi;
      logic         c52;
      iv   = inj_val(mode, sign);
      t    = exact(dbl, a, b) + iv;
      slo  = split ? 53'({$urandom, $urandom}) : 53'(0);
      clo  = t[52:0] - slo;
      lsum = {1'b0, slo} + {1'b0, clo};
      c52  = lsum[53];
      thi  = t[106:53];
      shi  = split ? 54'({$urandom, $urandom}) : 54'(0);
      chi  = thi - 54'(c52) - shi;
      @(negedge clk);
      settle();
      iss_sign = sign;
      iss_mode = mode;
      rnd_vld  = 1'b1;
      rnd_dbl  = dbl;
      rnd_sign = sign;
      rnd_mode = mode;
      sum_hi   = shi;
      cry_hi   = chi;
      cin      = c52;
      rbit     = t[52];
      sbit     = |t[51:0];
      #1;
      chk("R1", "injection", 128'(inj), iv);
      pend_vld = 1'b1;
      pend_exp = ref_round(dbl, sign, mode, a, b);
      pend_tag = tag;
   endtask

   task automatic idle();
      @(negedge clk);
      settle();
      rnd_vld  = 1'b0;
      sum_hi   = 54'({$urandom, $urandom});
      pend_vld = 1'b0;
   endtask

   function automatic logic [52:0] rnd_sig(input bit dbl);
      if (dbl) return {1'b1, 52'({$urandom, $urandom})};
      return 53'({1'b1, 23'($urandom)});
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [52:0] one_d, one_s, a, b;
      one_d = 53'(1) << 52;
      one_s = 53'(1) << 23;
      repeat (3) @(negedge clk);
      chk("R8", "reset valid", 128'(res_vld), 128'(0));
      chk("R8", "reset significand", 128'(res_sig), 128'(0));
      rst_n = 1'b1;

      // 1.0 x 1.0 in every mode and both precisions (R4, R2, R3, R6)
      for (int m = 0; m < 4; m++) begin
         run_op(1'b1, 1'b0, 2'(m), one_d, one_d, 1'b0, "R4/R2/R3 unity");
         run_op(1'b0, 1'b1, 2'(m), one_s, one_s, 1'b1, "R6 unity");
      end

      // Ties in [1,2): odd neighbour up, even neighbour stays (R3)
      run_op(1'b1, 1'b0, 2'b00, one_d + 53'd1, 53'(3) << 51, 1'b0, "R3 tie low odd");
      run_op(1'b1, 1'b0, 2'b00, one_d + 53'd3, 53'(3) << 51, 1'b1, "R3 tie low even");
      // Ties in [2,4) (R3)
      run_op(1'b1, 1'b0, 2'b00, 53'(3) << 51, (53'(3) << 51) + 53'd2, 1'b0, "R3 tie high odd");
      run_op(1'b1, 1'b1, 2'b00, 53'(3) << 51, (53'(3) << 51) + 53'd6, 1'b1, "R3 tie high even");
      // Single-precision tie (R6, R3)
      run_op(1'b0, 1'b0, 2'b00, one_s + 53'd1, 53'(24'hC00000), 1'b1, "R6 R3 tie");

      // Rounding past the largest significand (R5)
      a = {52'hFFFFFFFFFFFFF, 1'b0};
      b = one_d + 53'd1;
      run_op(1'b1, 1'b0, 2'b00, a, b, 1'b0, "R5 nearest");
      run_op(1'b1, 1'b0, 2'b10, a, b, 1'b1, "R5 up");
      run_op(1'b1, 1'b1, 2'b11, a, b, 1'b0, "R5 down neg");
      run_op(1'b1, 1'b0, 2'b01, a, b, 1'b1, "R4 near two");
      run_op(1'b0, 1'b0, 2'b00, 53'(24'hFFFFFE), 53'(24'h800001), 1'b0, "R5 R6 nearest");
      run_op(1'b0, 1'b1, 2'b11, 53'(24'hFFFFFE), 53'(24'h800001), 1'b1, "R5 R6 down neg");

      // Sign folding of directed modes (R2)
      a = rnd_sig(1'b1);
      b = rnd_sig(1'b1);
      run_op(1'b1, 1'b0, 2'b10, a, b, 1'b1, "R2 up pos");
      run_op(1'b1, 1'b1, 2'b10, a, b, 1'b1, "R2 up neg");
      run_op(1'b1, 1'b0, 2'b11, a, b, 1'b1, "R2 down pos");
      run_op(1'b1, 1'b1, 2'b11, a, b, 1'b1, "R2 down neg");

      // Same operation under two carry-save splits (R9)
      for (int i = 0; i < 20; i++) begin
         bit dbl;
         logic [1:0] m;
         dbl = 1'($urandom);
         m   = 2'($urandom);
         a   = rnd_sig(dbl);
         b   = rnd_sig(dbl);
         run_op(dbl, 1'b0, m, a, b, 1'b0, "R9 plain split");
         run_op(dbl, 1'b0, m, a, b, 1'b1, "R9 random split");
      end

      // Random traffic, back to back with occasional gaps
      for (int i = 0; i < 3000; i++) begin
         bit dbl, sg;
         logic [1:0] m;
         string tg;
         dbl = 1'($urandom);
         sg  = 1'($urandom);
         m   = 2'($urandom);
         tg  = (m == 2'b00) ? "R3" : (m == 2'b01) ? "R4" : "R2";
         if (!dbl) tg = {tg, "/R6"};
         run_op(dbl, sg, m, rnd_sig(dbl), rnd_sig(dbl), 1'b1, tg);
         if (($urandom % 8) == 0) idle();
      end

      idle();
      idle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule